// File: doc/BRIEF.md
# Status Report Frame Serializer

This block turns one status report into a framed stream of 16-bit words. A request handshake presents the report description: a report kind, the number of payload words, the controller's state code, a 64-bit board identity, a firmware version, a 32-bit trigger count and a 64-bit microsecond time value. When a request is accepted the serializer captures all of those fields and emits a fixed 15-word header. The header opens with a start marker, 0xFB01. The payload words are then taken one by one from a valid/ready source, and the frame is closed by a 0x04FE end marker.

The header carries a length word. It counts every word that follows the header, including the end marker, so it is always one more than the number of payload words. Both the output and the payload source use valid/ready flow control. A stalled consumer freezes the current word. A payload source with nothing to offer makes the output drop its valid for that cycle. The time value and trigger count are carried as given; clearing them at run start and stop is the producer's concern.

Top module: `status_frame_tx`

## Requirements
- R1: After reset, `out_valid` and `pl_ready` are low and `req_ready` is high.
- R2: The first word of every frame, presented in the cycle after the request is accepted, is 0xFB01.
- R3: After the start marker the header words are sent in this order: kind, length, state, board identity (4 words), firmware version, trigger count (2 words), time value (4 words). Every multi-word field goes out most significant 16-bit word first.
- R4: The length word equals the requested payload word count plus one.
- R5: The kind code (1 configuration, 2 rates, 3 board list, 4 error list, 5 register value) and the state code (0 undefined, 1 idle, 2 configuring, 3 running, 4 calibrating) are each sent zero-extended in the low bits of their own 16-bit word.
- R6: After the header exactly the requested number of payload words are forwarded, in source order and unchanged. A zero count forwards none.
- R7: The last word of every frame is 0x04FE, sent directly after the final payload word (or after the header when the count is zero).
- R8: All header fields are captured when the request is accepted. Later changes on the request inputs do not alter the frame in progress.
- R9: While payload is being forwarded, `out_valid` follows `pl_valid` and `pl_ready` follows `out_ready`. Outside that phase `pl_ready` stays low.
- R10: While `out_valid` is high and `out_ready` is low during header or end marker, the same word stays presented with `out_valid` high.
- R11: `req_ready` is high only when no frame is in progress. While it is high `out_valid` is low, and a new request is accepted no earlier than the cycle after the end marker is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Report request offered |
| req_ready | output | 1 | Serializer idle, request accepted when both high |
| req_kind | input | KIND_W (3) | Report kind code |
| req_count | input | COUNT_W (12) | Number of payload words |
| req_state | input | STATE_W (3) | Controller state code |
| req_board | input | BOARD_W (64) | Board identity |
| req_fw | input | 16 | Firmware version |
| req_trig | input | TRIG_W (32) | Trigger count |
| req_time | input | TIME_W (64) | Microsecond time value |
| pl_valid | input | 1 | Payload word available |
| pl_ready | output | 1 | Payload word taken when both high |
| pl_data | input | 16 | Payload word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer takes the word when both high |
| out_data | output | 16 | Output word |

## Verification
A wrong header index or capture register shows up on the very first output word it touches. It appears as a misplaced or stale field in the frame that is being sent. A payload counter that is off by one shifts the end marker by one word. That puts the wrong word into the frame tail and changes when `req_ready` returns. Both are visible within that same frame. A broken phase register either leaks `pl_ready` into the header or drops `out_valid` during a stall. The bench catches that in the first cycle it happens, because it compares every port on every clock.

// File: rtl/status_frame_pkg.sv
package status_frame_pkg;

   localparam int unsigned WORD_W = 16;

   typedef logic [WORD_W-1:0] word_t;

   localparam word_t SOF_WORD = 16'hFB01;
   localparam word_t EOF_WORD = 16'h04FE;

   // start marker, kind, length, state, firmware version
   localparam int unsigned SINGLE_HDR_WORDS = 5;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_HDR  = 2'd1,
      PH_PAY  = 2'd2,
      PH_TAIL = 2'd3
   } phase_t;

   function automatic int unsigned words_of(input int unsigned bits);
      return (bits + WORD_W - 1) / WORD_W;
   endfunction

endpackage

// File: rtl/status_frame_split.sv
module status_frame_split
   import status_frame_pkg::*;
#(
   parameter int unsigned FIELD_W   = 64,
   parameter bit          MSW_FIRST = 1'b1,
   localparam int unsigned N_WORDS  = words_of(FIELD_W)
) (
   input  logic [FIELD_W-1:0]        field,
   output logic [N_WORDS*WORD_W-1:0] words   // slot 0 is sent first
);

   if (FIELD_W % WORD_W != 0) begin : g_bad_width
      $error("status_frame_split: FIELD_W must be a multiple of the word width");
   end

   for (genvar i = 0; i < N_WORDS; i++) begin : g_word
      if (MSW_FIRST) begin : g_msw
         assign words[i*WORD_W +: WORD_W] = field[(N_WORDS-1-i)*WORD_W +: WORD_W];
      end else begin : g_lsw
         assign words[i*WORD_W +: WORD_W] = field[i*WORD_W +: WORD_W];
      end
   end

endmodule

// File: rtl/status_frame_capture.sv
module status_frame_capture
   import status_frame_pkg::*;
#(
   parameter int unsigned KIND_W  = 3,
   parameter int unsigned COUNT_W = 12,
   parameter int unsigned STATE_W = 3,
   parameter int unsigned BOARD_W = 64,
   parameter int unsigned TRIG_W  = 32,
   parameter int unsigned TIME_W  = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [KIND_W-1:0]  in_kind,
   input  logic [COUNT_W-1:0] in_count,
   input  logic [STATE_W-1:0] in_state,
   input  logic [BOARD_W-1:0] in_board,
   input  word_t              in_fw,
   input  logic [TRIG_W-1:0]  in_trig,
   input  logic [TIME_W-1:0]  in_time,
   output word_t              kind_q,
   output word_t              size_q,
   output word_t              state_q,
   output logic [BOARD_W-1:0] board_q,
   output word_t              fw_q,
   output logic [TRIG_W-1:0]  trig_q,
   output logic [TIME_W-1:0]  time_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q  <= '0;
         size_q  <= '0;
         state_q <= '0;
         board_q <= '0;
         fw_q    <= '0;
         trig_q  <= '0;
         time_q  <= '0;
      end else if (load) begin
         kind_q  <= WORD_W'(in_kind);
         size_q  <= WORD_W'(in_count) + word_t'(1);
         state_q <= WORD_W'(in_state);
         board_q <= in_board;
         fw_q    <= in_fw;
         trig_q  <= in_trig;
         time_q  <= in_time;
      end
   end

   // R4: the length word counts the end marker on top of the payload
   assert_size_plus_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (size_q == WORD_W'($past(in_count)) + word_t'(1)));

endmodule

// File: rtl/status_frame_hdr.sv
module status_frame_hdr
   import status_frame_pkg::*;
#(
   parameter int unsigned BOARD_W   = 64,
   parameter int unsigned TRIG_W    = 32,
   parameter int unsigned TIME_W    = 64,
   parameter bit          MSW_FIRST = 1'b1,
   localparam int unsigned BOARD_N  = words_of(BOARD_W),
   localparam int unsigned TRIG_N   = words_of(TRIG_W),
   localparam int unsigned TIME_N   = words_of(TIME_W),
   localparam int unsigned HDR_N    = SINGLE_HDR_WORDS + BOARD_N + TRIG_N + TIME_N,
   localparam int unsigned IDX_W    = $clog2(HDR_N)
) (
   input  word_t              kind_q,
   input  word_t              size_q,
   input  word_t              state_q,
   input  logic [BOARD_W-1:0] board_q,
   input  word_t              fw_q,
   input  logic [TRIG_W-1:0]  trig_q,
   input  logic [TIME_W-1:0]  time_q,
   input  logic [IDX_W-1:0]   idx,
   output word_t              hdr_word
);

   localparam int unsigned BOARD_AT = 4;
   localparam int unsigned FW_AT    = BOARD_AT + BOARD_N;
   localparam int unsigned TRIG_AT  = FW_AT + 1;
   localparam int unsigned TIME_AT  = TRIG_AT + TRIG_N;

   logic [BOARD_N*WORD_W-1:0] board_w;
   logic [TRIG_N*WORD_W-1:0]  trig_w;
   logic [TIME_N*WORD_W-1:0]  time_w;
   word_t                     slot [HDR_N];

   status_frame_split #(.FIELD_W(BOARD_W), .MSW_FIRST(MSW_FIRST)) u_split_board (
      .field(board_q), .words(board_w));
   status_frame_split #(.FIELD_W(TRIG_W), .MSW_FIRST(MSW_FIRST)) u_split_trig (
      .field(trig_q), .words(trig_w));
   status_frame_split #(.FIELD_W(TIME_W), .MSW_FIRST(MSW_FIRST)) u_split_time (
      .field(time_q), .words(time_w));

   assign slot[0]     = SOF_WORD;
   assign slot[1]     = kind_q;
   assign slot[2]     = size_q;
   assign slot[3]     = state_q;
   assign slot[FW_AT] = fw_q;

   for (genvar i = 0; i < BOARD_N; i++) begin : g_board
      assign slot[BOARD_AT+i] = board_w[i*WORD_W +: WORD_W];
   end
   for (genvar i = 0; i < TRIG_N; i++) begin : g_trig
      assign slot[TRIG_AT+i] = trig_w[i*WORD_W +: WORD_W];
   end
   for (genvar i = 0; i < TIME_N; i++) begin : g_time
      assign slot[TIME_AT+i] = time_w[i*WORD_W +: WORD_W];
   end

   always_comb begin
      hdr_word = '0;
      for (int k = 0; k < HDR_N; k++) begin
         if (idx == IDX_W'(k)) hdr_word = slot[k];
      end
   end

endmodule

// File: rtl/status_frame_ctrl.sv
module status_frame_ctrl
   import status_frame_pkg::*;
#(
   parameter int unsigned HDR_N   = 15,
   parameter int unsigned COUNT_W = 12,
   localparam int unsigned IDX_W  = $clog2(HDR_N)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [COUNT_W-1:0] req_count,
   input  logic               pl_valid,
   input  logic               out_ready,
   output logic               req_ready,
   output logic               load,
   output phase_t             phase,
   output logic [IDX_W-1:0]   idx,
   output logic               pl_ready,
   output logic               out_valid
);

   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(HDR_N - 1);

   logic [COUNT_W-1:0] remain;
   logic               hdr_last;
   logic               pay_fire;

   assign req_ready = (phase == PH_IDLE);
   assign load      = req_valid && req_ready;
   assign hdr_last  = (idx == IDX_LAST);
   assign pay_fire  = (phase == PH_PAY) && pl_valid && out_ready;
   assign pl_ready  = (phase == PH_PAY) && out_ready;

   always_comb begin
      unique case (phase)
         PH_HDR, PH_TAIL: out_valid = 1'b1;
         PH_PAY:          out_valid = pl_valid;
         default:         out_valid = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         idx    <= '0;
         remain <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: begin
               if (load) begin
                  phase  <= PH_HDR;
                  idx    <= '0;
                  remain <= req_count;
               end
            end
            PH_HDR: begin
               if (out_ready) begin
                  if (hdr_last) begin
                     idx   <= '0;
                     phase <= (remain == '0) ? PH_TAIL : PH_PAY;
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end
            end
            PH_PAY: begin
               if (pay_fire) begin
                  remain <= remain - 1'b1;
                  if (remain == COUNT_W'(1)) phase <= PH_TAIL;
               end
            end
            PH_TAIL: begin
               if (out_ready) phase <= PH_IDLE;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   // R6: the payload phase is never entered or kept with nothing left to send
   assert_remain_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_PAY) |-> (remain != '0));

   // R3: the header ends after its last slot is taken
   assert_hdr_leaves_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_HDR && out_ready && hdr_last) |=> (phase != PH_HDR));

   // R7: end marker taken means the frame is over
   assert_tail_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_TAIL && out_ready) |=> req_ready);

endmodule

// File: rtl/status_frame_tx.sv
module status_frame_tx
   import status_frame_pkg::*;
#(
   parameter int unsigned KIND_W    = 3,
   parameter int unsigned COUNT_W   = 12,
   parameter int unsigned STATE_W   = 3,
   parameter int unsigned BOARD_W   = 64,
   parameter int unsigned TRIG_W    = 32,
   parameter int unsigned TIME_W    = 64,
   parameter bit          MSW_FIRST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [KIND_W-1:0]  req_kind,
   input  logic [COUNT_W-1:0] req_count,
   input  logic [STATE_W-1:0] req_state,
   input  logic [BOARD_W-1:0] req_board,
   input  logic [15:0]        req_fw,
   input  logic [TRIG_W-1:0]  req_trig,
   input  logic [TIME_W-1:0]  req_time,
   input  logic               pl_valid,
   output logic               pl_ready,
   input  logic [15:0]        pl_data,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [15:0]        out_data
);

   localparam int unsigned HDR_N = SINGLE_HDR_WORDS + words_of(BOARD_W)
                                   + words_of(TRIG_W) + words_of(TIME_W);
   localparam int unsigned IDX_W = $clog2(HDR_N);

   if (COUNT_W >= WORD_W) begin : g_bad_count
      $error("status_frame_tx: COUNT_W must leave room for the end marker in the length word");
   end
   if (KIND_W > WORD_W || STATE_W > WORD_W) begin : g_bad_code
      $error("status_frame_tx: code fields must fit one word");
   end

   logic               load;
   phase_t             phase;
   logic [IDX_W-1:0]   idx;
   word_t              kind_q, size_q, state_q, fw_q, hdr_word;
   logic [BOARD_W-1:0] board_q;
   logic [TRIG_W-1:0]  trig_q;
   logic [TIME_W-1:0]  time_q;

   status_frame_ctrl #(.HDR_N(HDR_N), .COUNT_W(COUNT_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_count (req_count),
      .pl_valid  (pl_valid),
      .out_ready (out_ready),
      .req_ready (req_ready),
      .load      (load),
      .phase     (phase),
      .idx       (idx),
      .pl_ready  (pl_ready),
      .out_valid (out_valid)
   );

   status_frame_capture #(
      .KIND_W(KIND_W), .COUNT_W(COUNT_W), .STATE_W(STATE_W),
      .BOARD_W(BOARD_W), .TRIG_W(TRIG_W), .TIME_W(TIME_W)
   ) u_capture (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .in_kind  (req_kind),
      .in_count (req_count),
      .in_state (req_state),
      .in_board (req_board),
      .in_fw    (req_fw),
      .in_trig  (req_trig),
      .in_time  (req_time),
      .kind_q   (kind_q),
      .size_q   (size_q),
      .state_q  (state_q),
      .board_q  (board_q),
      .fw_q     (fw_q),
      .trig_q   (trig_q),
      .time_q   (time_q)
   );

   status_frame_hdr #(
      .BOARD_W(BOARD_W), .TRIG_W(TRIG_W), .TIME_W(TIME_W), .MSW_FIRST(MSW_FIRST)
   ) u_hdr (
      .kind_q   (kind_q),
      .size_q   (size_q),
      .state_q  (state_q),
      .board_q  (board_q),
      .fw_q     (fw_q),
      .trig_q   (trig_q),
      .time_q   (time_q),
      .idx      (idx),
      .hdr_word (hdr_word)
   );

   always_comb begin
      unique case (phase)
         PH_HDR:  out_data = hdr_word;
         PH_PAY:  out_data = pl_data;
         PH_TAIL: out_data = EOF_WORD;
         default: out_data = '0;
      endcase
   end

   // R2: start marker comes first
   assert_sof_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (out_valid && out_data == SOF_WORD));

   // R10: a stalled header or end-marker word is held
   assert_hold_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && phase != PH_PAY) |=> (out_valid && $stable(out_data)));

   // R11: nothing leaves while a new request can be taken
   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!out_valid && !pl_ready));

endmodule

// File: tb/status_frame_tx_bench.sv
module status_frame_tx_bench;

   localparam int LIMIT = 100000;
   localparam logic [15:0] SOF = 16'hFB01;
   localparam logic [15:0] EOF = 16'h04FE;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [2:0]  req_kind = '0;
   logic [11:0] req_count = '0;
   logic [2:0]  req_state = '0;
   logic [63:0] req_board = '0;
   logic [15:0] req_fw = '0;
   logic [31:0] req_trig = '0;
   logic [63:0] req_time = '0;
   logic        pl_valid = 1'b0;
   logic        pl_ready;
   logic [15:0] pl_data = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [15:0] out_data;

   always #10 clk = ~clk;

   status_frame_tx u_status_frame_tx (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_kind(req_kind), .req_count(req_count), .req_state(req_state),
      .req_board(req_board), .req_fw(req_fw), .req_trig(req_trig), .req_time(req_time),
      .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
   );

   typedef struct {
      logic [2:0]  kind;
      int          count;
      logic [2:0]  state;
      logic [63:0] board;
      logic [15:0] fw;
      logic [31:0] trig;
      logic [63:0] tval;
      int          rmode;
      int          vmode;
   } desc_t;

   desc_t       dq[$];
   logic [15:0] exp_q[$];
   bit          kind_q[$];   // 1 = payload word
   string       tag_q[$];
   logic [15:0] src_q[$];

   int checks = 0;
   int errors = 0;
   int frame_no = 0;
   int cur_rmode = 0;
   int cur_vmode = 0;
   logic [15:0] lfsr = 16'hACE1;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exv);
      end
   endtask

   task automatic push_w(input logic [15:0] w, input bit pay, input string tag);
      exp_q.push_back(w);
      kind_q.push_back(pay);
      tag_q.push_back(tag);
   endtask

   // expected frame from the requirements R2..R7
   task automatic push_frame(input desc_t d, input int fno);
      push_w(SOF, 1'b0, "R2");
      push_w({13'd0, d.kind}, 1'b0, "R5 kind");
      push_w(16'(d.count + 1), 1'b0, "R4");
      push_w({13'd0, d.state}, 1'b0, "R5 state");
      for (int i = 3; i >= 0; i--) push_w(d.board[i*16 +: 16], 1'b0, "R3 R8 board");
      push_w(d.fw, 1'b0, "R3 R8 fw");
      for (int i = 1; i >= 0; i--) push_w(d.trig[i*16 +: 16], 1'b0, "R3 R8 trig");
      for (int i = 3; i >= 0; i--) push_w(d.tval[i*16 +: 16], 1'b0, "R3 R8 time");
      for (int k = 0; k < d.count; k++) begin
         logic [15:0] pw;
         pw = {8'(fno), 8'(k)} ^ 16'h5A00;
         push_w(pw, 1'b1, "R6");
         src_q.push_back(pw);
      end
      push_w(EOF, 1'b0, "R7");
      cur_rmode = d.rmode;
      cur_vmode = d.vmode;
   endtask

   task automatic add(input logic [2:0] k, input int n, input logic [2:0] s, input int rm, input int vm);
      desc_t d;
      d.kind  = k;
      d.count = n;
      d.state = s;
      d.board = {16'h1000 + 16'(n), 16'h2200 + 16'(k), 16'h3300 + 16'(s), 16'h4400 + 16'(rm)};
      d.fw    = 16'h0E00 + 16'(n);
      d.trig  = {16'hBEEF, 16'h0100 + 16'(n)};
      d.tval  = {16'h0A0B, 16'h0C0D, 16'h0E0F, 16'h1100 + 16'(vm)};
      d.rmode = rm;
      d.vmode = vm;
      dq.push_back(d);
   endtask

   initial begin
      bit p_out, p_req, p_hold, p_pl;
      int cycles;
      p_out = 0; p_req = 0; p_hold = 0; p_pl = 0;
      cycles = 0;

      add(3'd1, 3,  3'd1, 0, 0);
      add(3'd2, 0,  3'd3, 0, 0);   // zero payload: only end marker (R6, R7)
      add(3'd3, 1,  3'd0, 1, 1);
      add(3'd4, 20, 3'd2, 1, 2);   // payload source mostly stalled (R9)
      add(3'd5, 7,  3'd4, 2, 0);   // consumer mostly stalled (R10)
      add(3'd1, 0,  3'd2, 2, 1);
      add(3'd2, 40, 3'd3, 1, 1);
      add(3'd5, 2,  3'd1, 0, 2);

      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'd0);
      chk(pl_ready == 1'b0, "R1 pl_ready", 64'(pl_ready), 64'd0);
      chk(req_ready == 1'b1, "R1 req_ready", 64'(req_ready), 64'd1);
      rst_n = 1'b1;

      while (cycles < LIMIT) begin
         @(negedge clk);
         cycles++;
         // account for transfers of the previous rising edge
         if (p_out && exp_q.size() > 0) begin
            void'(exp_q.pop_front());
            void'(kind_q.pop_front());
            void'(tag_q.pop_front());
         end
         if (p_pl && src_q.size() > 0) void'(src_q.pop_front());
         if (p_req) begin
            push_frame(dq[0], frame_no);
            void'(dq.pop_front());
            frame_no++;
            req_valid = 1'b0;
            // R8: disturb every request field while the frame runs
            req_kind  = ~req_kind;
            req_count = ~req_count;
            req_state = ~req_state;
            req_board = ~req_board;
            req_fw    = ~req_fw;
            req_trig  = ~req_trig;
            req_time  = ~req_time;
         end
         if (dq.size() == 0 && exp_q.size() == 0) break;

         // drive
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (!req_valid && dq.size() > 0 && !p_req) begin
            req_valid = 1'b1;   // offered early, held until idle (R11)
            req_kind  = dq[0].kind;
            req_count = 12'(dq[0].count);
            req_state = dq[0].state;
            req_board = dq[0].board;
            req_fw    = dq[0].fw;
            req_trig  = dq[0].trig;
            req_time  = dq[0].tval;
         end
         case (cur_rmode)
            0:       out_ready = 1'b1;
            1:       out_ready = lfsr[0];
            default: out_ready = (lfsr[1:0] == 2'b00);
         endcase
         case (cur_vmode)
            0:       pl_valid = (src_q.size() > 0);
            1:       pl_valid = (src_q.size() > 0) && (lfsr[5] | lfsr[7]);
            default: pl_valid = (src_q.size() > 0) && lfsr[9] && lfsr[4];
         endcase
         pl_data = (src_q.size() > 0) ? src_q[0] : 16'h0;

         #1;
         if (exp_q.size() == 0) begin
            chk(out_valid == 1'b0, "R11 idle out_valid", 64'(out_valid), 64'd0);
            chk(req_ready == 1'b1, "R11 idle req_ready", 64'(req_ready), 64'd1);
            chk(pl_ready == 1'b0, "R9 idle pl_ready", 64'(pl_ready), 64'd0);
         end else begin
            chk(req_ready == 1'b0, "R11 busy req_ready", 64'(req_ready), 64'd0);
            if (!kind_q[0]) begin
               chk(out_valid == 1'b1 && out_data == exp_q[0], p_hold ? "R10 held word" : tag_q[0],
                   {47'd0, out_valid, out_data}, {47'd0, 1'b1, exp_q[0]});
               chk(pl_ready == 1'b0, "R9 pl_ready outside payload", 64'(pl_ready), 64'd0);
            end else begin
               chk(out_valid == pl_valid, "R9 out_valid follows source", 64'(out_valid), 64'(pl_valid));
               chk(pl_ready == out_ready, "R9 pl_ready follows consumer", 64'(pl_ready), 64'(out_ready));
               if (out_valid) chk(out_data == exp_q[0], "R6 payload word", 64'(out_data), 64'(exp_q[0]));
            end
         end
         p_out  = out_valid && out_ready;
         p_pl   = pl_valid && pl_ready;
         p_req  = req_valid && req_ready;
         p_hold = out_valid && !out_ready;
      end

      if (cycles >= LIMIT) chk(1'b0, "watchdog", 64'(cycles), 64'(LIMIT));
      chk(frame_no == 8, "R6 R7 frames completed", 64'(frame_no), 64'd8);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule